// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the column address for every beat of a read burst in a synchronous memory. A one-cycle start pulse loads a starting address, a burst length of four or eight beats and an ordering: sequential (count up and wrap inside the aligned group) or interleaved (start bits XOR beat number). On each enabled clock edge the registered output moves to the next beat's address. A valid flag accompanies the address, and a last-beat flag marks the final beat of the burst.

Only the low address bits covered by the burst length change. All bits above them keep the start value for the whole burst. A synchronous clock enable freezes the sequencer: while it is sampled low, the outputs hold and a start pulse has no effect. The sequence continues on the first edge at which the enable is high again. A start pulse during a burst abandons that burst and begins a new one.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_valid and last_beat are 0 and addr_out is all zeros.
- R2: At an edge where ce and start are both 1, the outputs after that edge show addr_out equal to start_addr, addr_valid 1 and last_beat 0. This is beat 0.
- R3: With interleave = 0 (sequential), the low bits of beat i equal (start low bits + i) modulo the burst length.
- R4: With interleave = 1 (interleaved), the low bits of beat i equal the start low bits XOR i.
- R5: len8 = 0 selects 4 beats, and only addr_out[1:0] follows the ordering. len8 = 1 selects 8 beats, and only addr_out[2:0] follows it. All higher bits equal start_addr for every beat.
- R6: last_beat is 1 exactly while the final beat (beat 3 or beat 7) is shown. At the next enabled edge without start, addr_valid and last_beat go to 0, and they stay 0 until the next start.
- R7: At an edge where ce is 0, addr_out, addr_valid and last_beat keep their values and start is ignored. Advancing resumes at the first edge where ce is 1.
- R8: A start at an enabled edge during an active burst restarts from beat 0 of the new start_addr, using the new length and ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Synchronous clock enable; 0 freezes the sequencer |
| start | input | 1 | Begin a burst from start_addr |
| start_addr | input | AW | Starting address of the burst |
| len8 | input | 1 | Burst length: 0 = 4 beats, 1 = 8 beats |
| interleave | input | 1 | Ordering: 0 = sequential wrap, 1 = interleaved XOR |
| addr_out | output | AW | Address of the current beat (registered) |
| addr_valid | output | 1 | addr_out holds a beat of an active burst |
| last_beat | output | 1 | Current beat is the final one of the burst |

## Verification
A wrong beat counter or wrong base register shows up on addr_out at the very next enabled edge. Examples are a sum that carries into bit 2 during a 4-beat burst, or a sequential wrap where an XOR was needed. A miscounted length shows up on last_beat, either one edge early or one edge late, and it also shows up as addr_valid staying high or dropping at the wrong time. A clock enable that does not fully gate the registers shows up during a stall as a changed address, or as a restart that should have been ignored.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          len8,
  input  logic          interleave,
  output logic [AW-1:0] addr_out,
  output logic          addr_valid,
  output logic          last_beat
);

  logic [AW-1:0] base_q, addr_q;
  logic [2:0]    idx_q;
  logic          len8_q, il_q, valid_q, last_q;

  logic [2:0]    nxt_idx, mask, low_seq, low_il, low_sel;
  logic [AW-1:0] nxt_addr;
  logic          nxt_last;

  assign nxt_idx  = idx_q + 3'd1;
  assign mask     = len8_q ? 3'd7 : 3'd3;
  assign low_seq  = base_q[2:0] + nxt_idx;
  assign low_il   = base_q[2:0] ^ nxt_idx;
  assign low_sel  = (il_q ? low_il : low_seq) & mask;
  assign nxt_addr = {base_q[AW-1:3], (base_q[2:0] & ~mask) | low_sel};
  assign nxt_last = (nxt_idx == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      len8_q  <= 1'b0;
      il_q    <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (ce) begin
      if (start) begin
        base_q  <= start_addr;
        addr_q  <= start_addr;
        idx_q   <= '0;
        len8_q  <= len8;
        il_q    <= interleave;
        valid_q <= 1'b1;
        last_q  <= 1'b0;
      end else if (valid_q) begin
        if (last_q) begin
          valid_q <= 1'b0;
          last_q  <= 1'b0;
        end else begin
          idx_q  <= nxt_idx;
          addr_q <= nxt_addr;
          last_q <= nxt_last;
        end
      end
    end
  end

  assign addr_out   = addr_q;
  assign addr_valid = valid_q;
  assign last_beat  = last_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] addr_out,
  input logic          addr_valid,
  input logic          last_beat
);

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ce && start |=> addr_valid && !last_beat && addr_out == $past(start_addr)); // R2

  AST_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !start && addr_valid |=> addr_out[AW-1:3] == $past(addr_out[AW-1:3])); // R5

  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> addr_valid); // R6

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !start && last_beat |=> !addr_valid && !last_beat); // R6

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !addr_valid |=> !addr_valid); // R6

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(addr_out) && $stable(addr_valid) && $stable(last_beat)); // R7

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) chk_i (.*);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          len8 = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] addr_out;
  logic          addr_valid;
  logic          last_beat;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .start_addr(start_addr),
    .len8(len8), .interleave(interleave), .addr_out(addr_out),
    .addr_valid(addr_valid), .last_beat(last_beat)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, int i, logic l8, logic il);
    logic [2:0] m, lo;
    m  = l8 ? 3'd7 : 3'd3;
    lo = il ? (s[2:0] ^ 3'(i)) : (s[2:0] + 3'(i));
    exp_addr = {s[AW-1:3], (s[2:0] & ~m) | (lo & m)};
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // beat b of the burst (s,l8,il) is expected on the outputs; b == L means idle
  task automatic chk_beat(string req, logic [AW-1:0] s, int b, logic l8, logic il);
    int n = l8 ? 8 : 4;
    if (b < n) begin
      chk({req, " valid"}, AW'(addr_valid), AW'(1));
      chk({req, " addr"}, addr_out, exp_addr(s, b, l8, il));
      chk({req, " last (R6)"}, AW'(last_beat), AW'(b == n - 1));
    end else begin
      chk({req, " idle valid (R6)"}, AW'(addr_valid), AW'(0));
      chk({req, " idle last (R6)"}, AW'(last_beat), AW'(0));
    end
  endtask

  // run a burst with random stalls; at each negedge check, then set next inputs
  task automatic burst(logic [AW-1:0] s, logic l8, logic il, int stall_pct, string req);
    int n = l8 ? 8 : 4;
    int b = 0;
    @(negedge clk);
    start = 1'b1; ce = 1'b1; start_addr = s; len8 = l8; interleave = il;
    @(negedge clk);
    start = 1'b0;
    while (b <= n) begin
      chk_beat(req, s, b, l8, il);
      if (b == n) break;
      if (($urandom % 100) < stall_pct) begin
        ce = 1'b0;
        start = ($urandom % 2) == 1;           // R7: start while frozen is ignored
        start_addr = AW'($urandom);
        len8 = ~l8; interleave = ~il;
      end else begin
        ce = 1'b1; start = 1'b0;
        b++;
      end
      @(negedge clk);
    end
    ce = 1'b1; start = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    @(negedge clk);
    chk("R1 valid", AW'(addr_valid), AW'(0));
    chk("R1 last", AW'(last_beat), AW'(0));
    chk("R1 addr", addr_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    ce = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", AW'(addr_valid), AW'(0));

    burst(10'h002, 1'b0, 1'b0, 0, "R3 seq len4 start 2");
    burst(10'h3FE, 1'b0, 1'b0, 0, "R5 seq len4 no carry");
    burst(10'h005, 1'b1, 1'b1, 0, "R4 il len8 start 5");
    burst(10'h2A7, 1'b1, 1'b0, 0, "R5 seq len8 high held");
    burst(10'h1C3, 1'b0, 1'b1, 0, "R4 il len4");
    burst(10'h0F6, 1'b1, 1'b0, 50, "R7 seq len8 stalls");
    burst(10'h131, 1'b0, 1'b1, 60, "R7 il len4 stalls");

    // R2: start loads beat 0
    @(negedge clk);
    start = 1'b1; start_addr = 10'h155; len8 = 1'b1; interleave = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R2 load addr", addr_out, 10'h155);
    chk("R2 load valid", AW'(addr_valid), AW'(1));
    @(negedge clk);
    @(negedge clk);
    // R8: restart mid-burst with new params
    start = 1'b1; start_addr = 10'h0AA; len8 = 1'b0; interleave = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_beat("R8 restart", 10'h0AA, 0, 1'b0, 1'b1);
    for (int b = 1; b <= 4; b++) begin
      @(negedge clk);
      chk_beat("R8 restart", 10'h0AA, b, 1'b0, 1'b1);
    end

    // R7: freeze on last beat, then idle on resume
    @(negedge clk);
    start = 1'b1; start_addr = 10'h3F1; len8 = 1'b0; interleave = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int b = 1; b <= 3; b++) @(negedge clk);
    chk_beat("R6 last beat", 10'h3F1, 3, 1'b0, 1'b0);
    ce = 1'b0; start = 1'b1; start_addr = 10'h000;
    repeat (3) @(negedge clk);
    chk_beat("R7 frozen on last", 10'h3F1, 3, 1'b0, 1'b0);
    ce = 1'b1; start = 1'b0;
    @(negedge clk);
    chk_beat("R7 resume to idle", 10'h3F1, 4, 1'b0, 1'b0);

    for (int k = 0; k < 200; k++)
      burst(AW'($urandom), 1'($urandom), 1'($urandom), 30, "R3/R4 random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule